// File: doc/BRIEF.md
# Pipelined ADC Digital Error Correction

This block turns the per-stage decisions of a twelve-stage, 1.5-bit-per-stage pipelined converter into one binary sample. Each analog stage resolves one redundant digit (0, 1 or 2) and passes a residue on. So the digits of one sample reach the digital side at staggered times. The stages run on a shared rotating three-phase clock, so three consecutive stages cover two clock cycles. The skew between stages is therefore a stepped pattern, not a linear ramp.

The block holds each stage's code in a per-stage delay line until all twelve digits of a sample line up. It then adds the overlapping digits with a ripple of full-adder cells into a 13-bit word. It adds a fixed two's-complement offset constant to remove the mid-scale bias and clamps the result to the 12-bit range. The 12-bit code is registered, so it leaves the block on a clock edge. A sticky flag records any stage code that the redundant encoding forbids.

Top module: `pipeadc_corrector`

## Requirements
- R1: While `rst_i` is high at a rising edge, every delay register is cleared and `valid_o`, `code_o` and `illegal_o` read 0 after that edge. A sample whose valid was driven during reset never produces a `valid_o`.
- R2: Stage k (k = 1 is the most significant) occupies `stage_code_i[2k-1:2k-2]`, with bit 2k-1 as the upper decision bit. For a sample whose `in_valid_i` is high in cycle t, stage k's code must be driven in cycle t + off(k). The values of off(k) for k = 1..12 are 0,0,1,2,2,3,4,4,5,6,6,7. Codes from other cycles do not reach that sample.
- R3: `valid_o` is high for exactly one cycle, 9 cycles after the `in_valid_i` cycle, once for each sample. Samples may start on consecutive cycles.
- R4: Stage codes map to digits 00 -> 0, 01 -> 1, 11 -> 2. The merged sum is S = sum over k of digit(k) * 2^(12-k).
- R5: When 2047 <= S <= 6142, `code_o` = S - 2047. This equals adding 1100000000001 to S modulo 2^13.
- R6: When S < 2047, `code_o` = 0.
- R7: When S > 6142, `code_o` = 4095.
- R8: A stage code of 10 counts as digit 1. When its sample reaches the output, `illegal_o` goes high in the same cycle as that sample's `valid_o` and stays high until reset.
- R9: In cycles with `valid_o` low, `code_o` keeps the last output value (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Marks the cycle in which stage 1 of a new sample is presented |
| stage_code_i | input | 24 | Twelve 2-bit stage codes, stage k at bits [2k-1:2k-2] |
| code_o | output | 12 | Corrected, clamped output sample |
| valid_o | output | 1 | High for one cycle when `code_o` carries a new sample |
| illegal_o | output | 1 | Sticky flag: a forbidden stage code was seen |

## Verification
Uniform codes (all 00, all 01, all 11) pin down the digit mapping and the offset at zero, mid-scale and full scale. Sums placed exactly at 2046, 2047, 2048, 6141, 6142 and 6143 separate correct clamping from off-by-one errors at both ends. A burst of twelve back-to-back samples, each raising a different stage to 11 on a background of 01, gives every sample a distinct result. Any wrong per-stage delay therefore mixes digits from neighbouring samples and shows up as a wrong value. A 10 code placed next to a raised most significant stage shows that it is read as 1 rather than 0 or 2. The cycle in which the flag rises, and the way it stays set, check its timing and stickiness.

// File: rtl/pipeadc_corr_pkg.sv
package pipeadc_corr_pkg;

  // Deepest alignment line: three stages share two clock cycles.
  function automatic int max_depth(int n);
    return 1 + (2 * (n - 1)) / 3;
  endfunction

  // Register count for stage index s (0 = most significant stage).
  function automatic int align_depth(int s, int n);
    return max_depth(n) - (2 * s) / 3;
  endfunction

  function automatic logic fa_sum(logic x, logic y, logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(logic x, logic y, logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

endpackage

// File: rtl/pipeadc_stage_align.sv
module pipeadc_stage_align
  import pipeadc_corr_pkg::*;
#(
  parameter int NSTAGE = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  in_valid_i,
  input  logic [2*NSTAGE-1:0]   codes_i,
  output logic                  al_valid_o,
  output logic [2*NSTAGE-1:0]   al_codes_o
);

  localparam int VDEP = max_depth(NSTAGE);

  // One delay line per stage, depth taken from the stepped schedule.
  for (genvar s = 0; s < NSTAGE; s++) begin : g_lane
    localparam int DEP = align_depth(s, NSTAGE);
    logic [1:0] pipe [DEP];

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        for (int j = 0; j < DEP; j++) pipe[j] <= '0;
      end else begin
        pipe[0] <= codes_i[2*s+1 -: 2];
        for (int j = 1; j < DEP; j++) pipe[j] <= pipe[j-1];
      end
    end

    assign al_codes_o[2*s+1 -: 2] = pipe[DEP-1];
  end

  // The valid strobe travels with stage 1, which has the deepest line.
  logic [VDEP-1:0] vpipe;
  always_ff @(posedge clk_i) begin
    if (rst_i) vpipe <= '0;
    else       vpipe <= {vpipe[VDEP-2:0], in_valid_i};
  end
  assign al_valid_o = vpipe[VDEP-1];

endmodule

// File: rtl/pipeadc_digit_merge.sv
module pipeadc_digit_merge
  import pipeadc_corr_pkg::*;
#(
  parameter int NSTAGE = 12,
  localparam int W = NSTAGE + 1
) (
  input  logic [2*NSTAGE-1:0] al_codes_i,
  output logic [W-1:0]        merged_o,
  output logic                illegal_o
);

  logic [NSTAGE-1:0] a_eff, b_eff, bad;
  logic [W-1:0]      hi_word, lo_word, cy;

  // Sanitise: forbidden 10 is read as 01.
  for (genvar s = 0; s < NSTAGE; s++) begin : g_digit
    logic ra, rb;
    assign ra       = al_codes_i[2*s+1];
    assign rb       = al_codes_i[2*s];
    assign bad[s]   = ra & ~rb;
    assign a_eff[s] = ra & rb;
    assign b_eff[s] = ra | rb;
    // Digit 2 -> upper weight, digit 1 -> lower weight (uses complement of a).
    assign hi_word[W-1-s] = a_eff[s];
    assign lo_word[W-2-s] = b_eff[s] & ~a_eff[s];
  end
  assign hi_word[0]   = 1'b0;
  assign lo_word[W-1] = 1'b0;
  assign illegal_o    = |bad;

  // Ripple of full-adder cells.
  assign cy[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign merged_o[i] = fa_sum(hi_word[i], lo_word[i], cy[i]);
    if (i < W - 1) begin : g_cy
      assign cy[i+1] = fa_carry(hi_word[i], lo_word[i], cy[i]);
    end
  end

endmodule

// File: rtl/pipeadc_offset_clamp.sv
module pipeadc_offset_clamp #(
  parameter int NSTAGE = 12,
  localparam int W = NSTAGE + 1
) (
  input  logic [W-1:0]      merged_i,
  output logic [NSTAGE-1:0] code_o
);

  // Two's complement of the mid-scale-plus-half-LSB bias, modulo 2^W.
  localparam logic [W-1:0] CORR = W'((2 ** W) - ((2 ** (NSTAGE - 1)) - 1));

  function automatic logic [NSTAGE-1:0] correct_clamp(logic [W-1:0] s);
    logic [W:0] ext;
    ext = {1'b0, s} + {1'b1, CORR};
    if (ext[W])        return '0;
    else if (ext[W-1]) return '1;
    else               return ext[NSTAGE-1:0];
  endfunction

  assign code_o = correct_clamp(merged_i);

endmodule

// File: rtl/pipeadc_corrector.sv
module pipeadc_corrector
  import pipeadc_corr_pkg::*;
#(
  parameter int NSTAGE = 12
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                in_valid_i,
  input  logic [2*NSTAGE-1:0] stage_code_i,
  output logic [NSTAGE-1:0]   code_o,
  output logic                valid_o,
  output logic                illegal_o
);

  localparam int W      = NSTAGE + 1;
  localparam int LAT    = max_depth(NSTAGE) + 1;
  localparam int CW     = $clog2(LAT + 2) + 1;
  localparam logic [W-1:0] LO_LIM = W'((2 ** (NSTAGE - 1)) - 1);
  localparam logic [W-1:0] HI_LIM = W'((2 ** (NSTAGE - 1)) - 1 + (2 ** NSTAGE) - 1);

  logic                al_valid;
  logic [2*NSTAGE-1:0] al_codes;
  logic [W-1:0]        merged;
  logic                merge_bad;
  logic [NSTAGE-1:0]   code_next;

  pipeadc_stage_align #(.NSTAGE(NSTAGE)) u_align (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .in_valid_i (in_valid_i),
    .codes_i    (stage_code_i),
    .al_valid_o (al_valid),
    .al_codes_o (al_codes)
  );

  pipeadc_digit_merge #(.NSTAGE(NSTAGE)) u_merge (
    .al_codes_i (al_codes),
    .merged_o   (merged),
    .illegal_o  (merge_bad)
  );

  pipeadc_offset_clamp #(.NSTAGE(NSTAGE)) u_clamp (
    .merged_i (merged),
    .code_o   (code_next)
  );

  // Output register: synchronous to the clock despite adder delay.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      code_o    <= '0;
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= al_valid;
      if (al_valid) code_o <= code_next;
      if (al_valid && merge_bad) illegal_o <= 1'b1;
    end
  end

  // Checker state: samples accepted but not yet delivered.
  logic [CW-1:0] inflight;
  always_ff @(posedge clk_i) begin
    if (rst_i) inflight <= '0;
    else       inflight <= inflight + CW'(in_valid_i) - CW'(valid_o);
  end

  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (!valid_o && !illegal_o && code_o == '0));

  a_r3_valid_has_sample: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> (inflight != '0));

  a_r3_inflight_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    inflight <= CW'(LAT));

  a_r5_offset_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
    (al_valid && merged >= LO_LIM && merged <= HI_LIM)
      |=> ({1'b0, code_o} == $past(merged) - LO_LIM));

  a_r6_clamp_low: assert property (@(posedge clk_i) disable iff (rst_i)
    (al_valid && merged < LO_LIM) |=> (code_o == '0));

  a_r7_clamp_high: assert property (@(posedge clk_i) disable iff (rst_i)
    (al_valid && merged > HI_LIM) |=> (code_o == '1));

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    illegal_o |=> illegal_o);

  a_r9_hold_code: assert property (@(posedge clk_i) disable iff (rst_i)
    !al_valid |=> $stable(code_o));

endmodule

// File: tb/pipeadc_corrector_test.sv
module pipeadc_corrector_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [23:0] codes;
  logic [11:0] code_o;
  logic        valid_o;
  logic        illegal_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  pipeadc_corrector uut (
    .clk_i        (clk),
    .rst_i        (rst),
    .in_valid_i   (in_valid),
    .stage_code_i (codes),
    .code_o       (code_o),
    .valid_o      (valid_o),
    .illegal_o    (illegal_o)
  );

  // Arrival offset per stage (R2), stated independently of the RTL.
  int OFF [1:12] = '{0, 0, 1, 2, 2, 3, 4, 4, 5, 6, 6, 7};

  logic [23:0] smp_codes [0:31];
  int          smp_start [0:31];
  int          n_smp = 0;
  int          last_code = 0;
  bit          err_exp = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] put(logic [23:0] w, int k, logic [1:0] f);
    w[2*k-1 -: 2] = f;
    return w;
  endfunction

  function automatic logic [23:0] uniform(logic [1:0] f);
    logic [23:0] w = '0;
    for (int k = 1; k <= 12; k++) w = put(w, k, f);
    return w;
  endfunction

  function automatic int expect_code(logic [23:0] w);
    int sum = 0;
    int v;
    for (int k = 1; k <= 12; k++) begin
      logic [1:0] f = w[2*k-1 -: 2];
      int d = (f == 2'b11) ? 2 : ((f == 2'b00) ? 0 : 1);
      sum += d * (1 << (12 - k));
    end
    v = sum - 2047;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  function automatic bit has_bad(logic [23:0] w);
    for (int k = 1; k <= 12; k++)
      if (w[2*k-1 -: 2] == 2'b10) return 1'b1;
    return 1'b0;
  endfunction

  task automatic add_sample(logic [23:0] w, int start);
    smp_codes[n_smp] = w;
    smp_start[n_smp] = start;
    n_smp++;
  endtask

  task automatic run_schedule(string tag);
    int last = 0;
    for (int i = 0; i < n_smp; i++) if (smp_start[i] > last) last = smp_start[i];
    for (int c = 0; c <= last + 12; c++) begin
      int hit = -1;
      logic [23:0] w = '0;
      logic        v = 1'b0;
      @(negedge clk);
      for (int i = 0; i < n_smp; i++) if (smp_start[i] == c - 9) hit = i;
      if (hit >= 0) begin
        int e = expect_code(smp_codes[hit]);
        chk(valid_o == 1'b1, "R3", {tag, " valid"}, int'(valid_o), 1);
        chk(int'(code_o) == e, tag, "code", int'(code_o), e);
        last_code = e;
        if (has_bad(smp_codes[hit])) err_exp = 1'b1;
      end else begin
        chk(valid_o == 1'b0, "R3", {tag, " idle valid"}, int'(valid_o), 0);
        chk(int'(code_o) == last_code, "R9", {tag, " hold"}, int'(code_o), last_code);
      end
      chk(illegal_o == err_exp, "R8", {tag, " flag"}, int'(illegal_o), int'(err_exp));
      for (int i = 0; i < n_smp; i++) begin
        if (smp_start[i] == c) v = 1'b1;
        for (int k = 1; k <= 12; k++)
          if (c - smp_start[i] == OFF[k]) w[2*k-1 -: 2] = smp_codes[i][2*k-1 -: 2];
      end
      in_valid = v;
      codes    = w;
    end
    n_smp = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst      = 1'b1;
    in_valid = 1'b1;
    codes    = uniform(2'b11);
    repeat (3) @(negedge clk);
    rst      = 1'b0;
    in_valid = 1'b0;
    codes    = '0;
    @(negedge clk);
    chk(valid_o == 1'b0, "R1", "reset valid", int'(valid_o), 0);
    chk(code_o == 12'd0, "R1", "reset code", int'(code_o), 0);
    chk(illegal_o == 1'b0, "R1", "reset flag", int'(illegal_o), 0);
    last_code = 0;
    err_exp   = 1'b0;
  endtask

  // R1: valid driven during reset yields no output (idle checks in run).
  task automatic t_reset();
    do_reset();
    run_schedule("R1");
  endtask

  // R4/R5: digit mapping and offset with gaps between samples (R9 hold).
  task automatic t_midscale();
    add_sample(uniform(2'b01), 0);                          // 2048
    add_sample(put(uniform(2'b00), 1, 2'b11), 3);           // 2049
    add_sample(put(uniform(2'b00), 2, 2'b11), 6);           // 1
    add_sample(put(uniform(2'b00), 1, 2'b01), 10);          // 1
    run_schedule("R5");
  endtask

  // R6: low clamp around 2047.
  task automatic t_clamp_low();
    logic [23:0] w2047 = put(uniform(2'b01), 1, 2'b00);
    add_sample(uniform(2'b00), 0);                          // 0
    add_sample(w2047, 2);                                   // 0
    add_sample(put(w2047, 12, 2'b00), 4);                   // 2046 -> 0
    add_sample(put(uniform(2'b00), 12, 2'b11), 6);          // 2 -> 0
    run_schedule("R6");
  endtask

  // R7: high clamp around 6142.
  task automatic t_clamp_high();
    logic [23:0] w6142 = put(uniform(2'b11), 1, 2'b01);
    add_sample(uniform(2'b11), 0);                          // 4095
    add_sample(w6142, 1);                                   // 4095 exact
    add_sample(put(w6142, 12, 2'b01), 2);                   // 4094
    add_sample(put(uniform(2'b01), 1, 2'b11), 3);           // 6143 -> 4095
    run_schedule("R7");
  endtask

  // R2/R3: back-to-back walking samples, each value distinct.
  task automatic t_alignment();
    for (int j = 1; j <= 12; j++) add_sample(put(uniform(2'b01), j, 2'b11), j - 1);
    add_sample(uniform(2'b00), 12);
    add_sample(uniform(2'b11), 13);
    run_schedule("R2");
  endtask

  // R8: 10 read as 01, flag timing, stickiness, cleared by reset.
  task automatic t_illegal();
    logic [23:0] wb = put(put(uniform(2'b00), 1, 2'b11), 3, 2'b10); // 2561
    add_sample(uniform(2'b01), 0);
    add_sample(wb, 4);
    add_sample(uniform(2'b11), 8);
    run_schedule("R8");
    do_reset();
    chk(illegal_o == 1'b0, "R8", "flag after reset", int'(illegal_o), 0);
  endtask

  initial begin
    rst      = 1'b1;
    in_valid = 1'b0;
    codes    = '0;
    repeat (2) @(negedge clk);
    t_reset();
    t_midscale();
    t_clamp_low();
    t_clamp_high();
    t_alignment();
    t_illegal();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule